// File: doc/BRIEF.md
# Banked Memory Page Controller

This block maps the 64 KB address space of an 8-bit CPU onto a 1 MB ROM and a 512 KB RAM. The CPU window is split in two halves. The upper 32 KB always reaches one fixed RAM page. The lower 32 KB shows either one of 32 ROM pages or one of 16 RAM pages, as chosen by two write-only page registers. The CPU loads these registers with I/O port writes.

The block decodes the I/O strobe and the low address byte. From them it produces active-low chip selects for a parallel port, a UART and a real-time clock, and it finds writes to the two page registers. From the registers and CPU A15 it drives the extended ROM and RAM address lines and the active-low ROM and RAM chip selects.

Top module: `bank_map_ctrl`

## Requirements
- R1: After reset both page registers hold zero. A memory access below 0x8000 then selects ROM with `rom_page_o`=0, and an access at 0x8000 or above selects RAM with `ram_page_o`=0xF.
- R2: An I/O chip select goes low only while `iorq_ni` is low and the low address byte lies in 0x60–0x7F. Within that window, 0x60–0x67 selects `pio_cs_no`, 0x68–0x6F selects `uart_cs_no` and 0x70–0x77 selects `rtc_cs_no`. No more than one of them is low at a time.
- R3: In 0x78–0x7F a page-register write needs address bit 1 = 0. Address bit 2 = 0 picks the RAM register and bit 2 = 1 picks the ROM register. Address bit 0 is ignored, so 0x78/0x79 reach the RAM register and 0x7C/0x7D reach the ROM register. Writes to 0x7A, 0x7B, 0x7E and 0x7F change nothing.
- R4: A register takes the data held on `cpu_data_i` at the end of the write strobe. While the strobe is held, the outputs do not change. The new value appears after the first rising clock edge at which the strobe is seen inactive.
- R5: ROM register bits [4:0] drive `rom_page_o`, and every one of the 32 values reaches the ROM address lines.
- R6: ROM register bit 7 = 1 maps RAM into the lower window. A lower-window access then selects RAM with `ram_page_o` equal to RAM register bits [3:0], for all 16 values.
- R7: When CPU A15 = 1 during a memory access, RAM is selected, ROM is not, and `ram_page_o` is all ones, whatever either register holds.
- R8: When CPU A15 = 0 and ROM register bit 7 = 0, a memory access selects ROM and not RAM.
- R9: While `mreq_ni` is high, both `rom_cs_no` and `ram_cs_no` stay high.
- R10: I/O reads (`wr_ni` high) of the page-register ports leave both registers unchanged.
- R11: With RAM page 15 in the lower window, the lower window drives the same RAM page lines as the fixed upper page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 16 | CPU address bus |
| cpu_data_i | input | 8 | CPU data bus (write data) |
| mreq_ni | input | 1 | Memory request strobe, active low |
| iorq_ni | input | 1 | I/O request strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| rom_page_o | output | 5 | ROM address lines 15 to 19 |
| ram_page_o | output | 4 | RAM address lines 15 to 18 |
| rom_cs_no | output | 1 | ROM chip select, active low |
| ram_cs_no | output | 1 | RAM chip select, active low |
| pio_cs_no | output | 1 | Parallel port chip select, active low |
| uart_cs_no | output | 1 | UART chip select, active low |
| rtc_cs_no | output | 1 | Real-time clock chip select, active low |

## Verification
All chip selects and the page lines are combinational from the strobes, the address and the registers. The bench therefore applies each probe after a falling edge and samples a short delay later, in the same cycle. A register write takes effect at the first rising edge after its strobe is released. The bench releases the strobe at a falling edge and checks at the next falling edge, and it also checks during the held strobe that the old page is still driven. Read strobes and writes to the unused mirror addresses are followed by a memory probe that shows the page the register would have changed.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;
  // device groups inside the on-board I/O window, in address order
  typedef enum logic [1:0] {
    GRP_PIO  = 2'd0,
    GRP_UART = 2'd1,
    GRP_RTC  = 2'd2,
    GRP_PAGE = 2'd3
  } io_grp_e;

  localparam int unsigned N_GRP = 4;
endpackage

// File: rtl/bank_io_decode.sv
module bank_io_decode
  import bank_map_pkg::*;
#(
  parameter logic [7:0]  IO_BASE   = 8'h60,
  parameter int unsigned IO_SPAN_W = 5,
  parameter int unsigned GRP_W     = 3
) (
  input  logic [7:0] addr_lo_i,
  input  logic       iorq_ni,
  input  logic       wr_ni,
  output logic       pio_cs_no,
  output logic       uart_cs_no,
  output logic       rtc_cs_no,
  output logic       ram_hit_o,
  output logic       rom_hit_o
);
  localparam int unsigned SEL_W = IO_SPAN_W - GRP_W;

  logic             in_win;
  logic [SEL_W-1:0] grp;
  logic [N_GRP-1:0] grp_sel;
  logic             page_wr;

  assign in_win = !iorq_ni && (addr_lo_i[7:IO_SPAN_W] == IO_BASE[7:IO_SPAN_W]);
  assign grp    = addr_lo_i[IO_SPAN_W-1:GRP_W];

  for (genvar g = 0; g < N_GRP; g++) begin : g_sel
    assign grp_sel[g] = in_win && (grp == SEL_W'(g));
  end

  assign pio_cs_no  = !grp_sel[GRP_PIO];
  assign uart_cs_no = !grp_sel[GRP_UART];
  assign rtc_cs_no  = !grp_sel[GRP_RTC];

  // bit 1 must be clear; bit 0 is a don't-care
  assign page_wr   = grp_sel[GRP_PAGE] && !addr_lo_i[1] && !wr_ni;
  assign ram_hit_o = page_wr && !addr_lo_i[2];
  assign rom_hit_o = page_wr &&  addr_lo_i[2];
endmodule

// File: rtl/bank_page_reg.sv
module bank_page_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hit_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o
);
  logic         hit_q;
  logic [W-1:0] data_q;

  // track data while the strobe is held, commit when it ends
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q  <= 1'b0;
      data_q <= '0;
      q_o    <= '0;
    end else begin
      hit_q <= hit_i;
      if (hit_i) data_q <= data_i;
      if (hit_q && !hit_i) q_o <= data_q;
    end
  end
endmodule

// File: rtl/bank_mem_map.sv
module bank_mem_map #(
  parameter int unsigned ROM_PAGE_W = 5,
  parameter int unsigned RAM_PAGE_W = 4
) (
  input  logic                  a15_i,
  input  logic                  mreq_ni,
  input  logic                  lo_ram_i,
  input  logic [ROM_PAGE_W-1:0] rom_reg_i,
  input  logic [RAM_PAGE_W-1:0] ram_reg_i,
  output logic [ROM_PAGE_W-1:0] rom_page_o,
  output logic [RAM_PAGE_W-1:0] ram_page_o,
  output logic                  rom_cs_no,
  output logic                  ram_cs_no
);
  logic rom_sel;

  assign rom_sel    = !a15_i && !lo_ram_i;
  assign rom_page_o = rom_reg_i;
  // upper half pins RAM to its top page
  assign ram_page_o = ram_reg_i | {RAM_PAGE_W{a15_i}};
  assign rom_cs_no  = !(!mreq_ni && rom_sel);
  assign ram_cs_no  = !(!mreq_ni && !rom_sel);
endmodule

// File: rtl/bank_map_ctrl.sv
module bank_map_ctrl #(
  parameter int unsigned ROM_PAGE_W = 5,
  parameter int unsigned RAM_PAGE_W = 4,
  parameter int unsigned LO_RAM_BIT = 7,
  parameter logic [7:0]  IO_BASE    = 8'h60,
  parameter int unsigned IO_SPAN_W  = 5,
  parameter int unsigned GRP_W      = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [15:0]           cpu_addr_i,
  input  logic [7:0]            cpu_data_i,
  input  logic                  mreq_ni,
  input  logic                  iorq_ni,
  input  logic                  wr_ni,
  output logic [ROM_PAGE_W-1:0] rom_page_o,
  output logic [RAM_PAGE_W-1:0] ram_page_o,
  output logic                  rom_cs_no,
  output logic                  ram_cs_no,
  output logic                  pio_cs_no,
  output logic                  uart_cs_no,
  output logic                  rtc_cs_no
);
  localparam int unsigned ROM_REG_W = ROM_PAGE_W + 1;

  logic                  ram_hit, rom_hit;
  logic [ROM_REG_W-1:0]  rom_reg;
  logic [RAM_PAGE_W-1:0] ram_reg;

  bank_io_decode #(
    .IO_BASE(IO_BASE), .IO_SPAN_W(IO_SPAN_W), .GRP_W(GRP_W)
  ) u_dec (
    .addr_lo_i (cpu_addr_i[7:0]),
    .iorq_ni   (iorq_ni),
    .wr_ni     (wr_ni),
    .pio_cs_no (pio_cs_no),
    .uart_cs_no(uart_cs_no),
    .rtc_cs_no (rtc_cs_no),
    .ram_hit_o (ram_hit),
    .rom_hit_o (rom_hit)
  );

  // ROM register keeps the page bits plus the lower-window RAM select
  bank_page_reg #(.W(ROM_REG_W)) u_rom_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hit_i (rom_hit),
    .data_i({cpu_data_i[LO_RAM_BIT], cpu_data_i[ROM_PAGE_W-1:0]}),
    .q_o   (rom_reg)
  );

  bank_page_reg #(.W(RAM_PAGE_W)) u_ram_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hit_i (ram_hit),
    .data_i(cpu_data_i[RAM_PAGE_W-1:0]),
    .q_o   (ram_reg)
  );

  bank_mem_map #(.ROM_PAGE_W(ROM_PAGE_W), .RAM_PAGE_W(RAM_PAGE_W)) u_map (
    .a15_i     (cpu_addr_i[15]),
    .mreq_ni   (mreq_ni),
    .lo_ram_i  (rom_reg[ROM_REG_W-1]),
    .rom_reg_i (rom_reg[ROM_PAGE_W-1:0]),
    .ram_reg_i (ram_reg),
    .rom_page_o(rom_page_o),
    .ram_page_o(ram_page_o),
    .rom_cs_no (rom_cs_no),
    .ram_cs_no (ram_cs_no)
  );
endmodule

// File: rtl/bank_map_ctrl_chk.sv
module bank_map_ctrl_chk #(
  parameter int unsigned ROM_PAGE_W = 5,
  parameter int unsigned RAM_PAGE_W = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [15:0]           cpu_addr_i,
  input logic                  mreq_ni,
  input logic                  iorq_ni,
  input logic                  wr_ni,
  input logic [ROM_PAGE_W-1:0] rom_page_o,
  input logic [RAM_PAGE_W-1:0] ram_page_o,
  input logic                  rom_cs_no,
  input logic                  ram_cs_no,
  input logic                  pio_cs_no,
  input logic                  uart_cs_no,
  input logic                  rtc_cs_no
);
  // R7
  upper_ram_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mreq_ni && cpu_addr_i[15]) |-> (rom_cs_no && !ram_cs_no && (&ram_page_o)));

  // R9
  mem_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreq_ni |-> (rom_cs_no && ram_cs_no));

  // R2
  io_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({!pio_cs_no, !uart_cs_no, !rtc_cs_no}));

  // R2
  io_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iorq_ni |-> (pio_cs_no && uart_cs_no && rtc_cs_no));

  // R4
  held_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!iorq_ni && !wr_ni) |=> $stable(rom_page_o));

  // R8
  mem_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mreq_ni |-> (rom_cs_no != ram_cs_no));
endmodule

bind bank_map_ctrl bank_map_ctrl_chk #(
  .ROM_PAGE_W(ROM_PAGE_W), .RAM_PAGE_W(RAM_PAGE_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .cpu_addr_i(cpu_addr_i),
  .mreq_ni(mreq_ni), .iorq_ni(iorq_ni), .wr_ni(wr_ni),
  .rom_page_o(rom_page_o), .ram_page_o(ram_page_o),
  .rom_cs_no(rom_cs_no), .ram_cs_no(ram_cs_no),
  .pio_cs_no(pio_cs_no), .uart_cs_no(uart_cs_no), .rtc_cs_no(rtc_cs_no)
);

// File: tb/bank_map_ctrl_tb_top.sv
module bank_map_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic        mreq_n = 1'b1, iorq_n = 1'b1, wr_n = 1'b1;
  logic [4:0]  rom_page;
  logic [3:0]  ram_page;
  logic        rom_cs_n, ram_cs_n, pio_cs_n, uart_cs_n, rtc_cs_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_map_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cpu_addr_i(addr), .cpu_data_i(data),
    .mreq_ni(mreq_n), .iorq_ni(iorq_n), .wr_ni(wr_n),
    .rom_page_o(rom_page), .ram_page_o(ram_page),
    .rom_cs_no(rom_cs_n), .ram_cs_no(ram_cs_n),
    .pio_cs_no(pio_cs_n), .uart_cs_no(uart_cs_n), .rtc_cs_no(rtc_cs_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // full write cycle; register is committed by the time this returns
  task automatic io_write(input logic [7:0] port, input logic [7:0] val);
    @(negedge clk);
    addr = {8'h00, port}; data = val; iorq_n = 1'b0; wr_n = 1'b0;
    repeat (2) @(negedge clk);
    iorq_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
  endtask

  // memory probe: returns {rom_cs_n, ram_cs_n, rom_page, ram_page}
  task automatic mem_probe(input logic [15:0] a, output logic [10:0] r);
    @(negedge clk);
    addr = a; mreq_n = 1'b0;
    #1;
    r = {rom_cs_n, ram_cs_n, rom_page, ram_page};
    mreq_n = 1'b1;
  endtask

  task automatic t_reset;
    logic [10:0] r;
    mem_probe(16'h0000, r);
    chk("R1 lo rom_cs_n", r[10], 0);
    chk("R1 lo ram_cs_n", r[9], 1);
    chk("R1 rom_page", r[8:4], 0);
    mem_probe(16'h8000, r);
    chk("R1 hi ram_cs_n", r[9], 0);
    chk("R1 hi ram_page", r[3:0], 15);
  endtask

  task automatic t_io_decode;
    for (int a = 0; a < 256; a++) begin
      logic in_win;
      @(negedge clk);
      addr = {8'hA5, 8'(a)}; iorq_n = 1'b0; wr_n = 1'b1;
      #1;
      in_win = (a >= 8'h60) && (a <= 8'h7F);
      chk("R2 pio", pio_cs_n, !(in_win && a < 8'h68));
      chk("R2 uart", uart_cs_n, !(a >= 8'h68 && a <= 8'h6F));
      chk("R2 rtc", rtc_cs_n, !(a >= 8'h70 && a <= 8'h77));
    end
    @(negedge clk);
    iorq_n = 1'b1; addr = 16'h0068;
    #1;
    chk("R2 no strobe", {pio_cs_n, uart_cs_n, rtc_cs_n}, 3'b111);
  endtask

  task automatic t_rom_pages;
    logic [10:0] r;
    for (int p = 0; p < 32; p++) begin
      io_write(8'h7C, 8'(p));
      mem_probe(16'h1234, r);
      chk("R5 rom_page", r[8:4], p);
      chk("R8 rom_cs_n", r[10], 0);
      chk("R8 ram_cs_n", r[9], 1);
    end
  endtask

  task automatic t_ram_pages;
    logic [10:0] r;
    io_write(8'h7C, 8'h80);
    for (int p = 0; p < 16; p++) begin
      io_write(8'h78, 8'(p));
      mem_probe(16'h0100, r);
      chk("R6 ram_page", r[3:0], p);
      chk("R6 ram_cs_n", r[9], 0);
      chk("R6 rom_cs_n", r[10], 1);
    end
  endtask

  task automatic t_upper;
    logic [10:0] r;
    io_write(8'h78, 8'h03);
    io_write(8'h7C, 8'h00);
    mem_probe(16'hC000, r);
    chk("R7 ram_page rom on", r[3:0], 15);
    chk("R7 rom_cs_n", r[10], 1);
    io_write(8'h7C, 8'h80);
    mem_probe(16'hFFFF, r);
    chk("R7 ram_page ram on", r[3:0], 15);
    chk("R7 ram_cs_n", r[9], 0);
  endtask

  task automatic t_alias;
    logic [10:0] lo, hi;
    io_write(8'h7C, 8'h80);
    io_write(8'h78, 8'h0F);
    mem_probe(16'h0000, lo);
    mem_probe(16'h8000, hi);
    chk("R11 alias page", lo[3:0], hi[3:0]);
    chk("R11 alias cs", lo[9], hi[9]);
  endtask

  task automatic t_mirror;
    logic [10:0] r;
    io_write(8'h7C, 8'h80);
    io_write(8'h79, 8'h05);
    mem_probe(16'h0000, r);
    chk("R3 port 79", r[3:0], 5);
    io_write(8'h7A, 8'h09);
    io_write(8'h7B, 8'h0A);
    mem_probe(16'h0000, r);
    chk("R3 ports 7A/7B ignored", r[3:0], 5);
    io_write(8'h7D, 8'h07);
    mem_probe(16'h0000, r);
    chk("R3 port 7D", r[8:4], 7);
    chk("R3 port 7D lo_ram cleared", r[10], 0);
    io_write(8'h7E, 8'h1E);
    io_write(8'h7F, 8'h9F);
    mem_probe(16'h0000, r);
    chk("R3 ports 7E/7F ignored", r[8:4], 7);
    chk("R3 ports 7E/7F rom_cs_n", r[10], 0);
  endtask

  task automatic t_trailing;
    io_write(8'h7C, 8'h02);
    @(negedge clk);
    addr = 16'h007C; data = 8'h11; iorq_n = 1'b0; wr_n = 1'b0;
    repeat (2) @(negedge clk);
    data = 8'h19;
    repeat (2) @(negedge clk);
    chk("R4 held strobe", rom_page, 2);
    iorq_n = 1'b1; wr_n = 1'b1;
    #1;
    chk("R4 before edge", rom_page, 2);
    @(negedge clk);
    chk("R4 after release", rom_page, 5'h19);
  endtask

  task automatic t_read;
    io_write(8'h7C, 8'h04);
    @(negedge clk);
    addr = 16'h007C; data = 8'h1F; iorq_n = 1'b0; wr_n = 1'b1;
    repeat (2) @(negedge clk);
    iorq_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 read of rom port", rom_page, 4);
  endtask

  task automatic t_mreq;
    @(negedge clk);
    mreq_n = 1'b1; addr = 16'h0000;
    #1;
    chk("R9 idle lo", {rom_cs_n, ram_cs_n}, 2'b11);
    addr = 16'h8000;
    #1;
    chk("R9 idle hi", {rom_cs_n, ram_cs_n}, 2'b11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_io_decode;
    t_rom_pages;
    t_ram_pages;
    t_upper;
    t_alias;
    t_mirror;
    t_trailing;
    t_read;
    t_mreq;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule